// File: doc/BRIEF.md
# Snooping MSI Line Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line carries a tag, one data word and one of three coherence states: Invalid, Shared (clean, readable, possibly held elsewhere) or Exclusive (the only copy, writable, dirty). The CPU side presents reads and writes with a valid/ready handshake. Hits finish in the cycle they are presented. Misses are handed to a bus sequencer. The sequencer first asks for the bus, and only after the grant does it place an optional write-back of a dirty victim, followed by a read-miss or write-miss, and then waits for the fill.

At the same time the controller watches every transaction that other caches put on the bus. A foreign write-miss invalidates a matching line. A foreign read-miss or write-miss that finds the line dirty raises an abort toward memory and supplies the dirty word, so that memory drops its own reply. A snoop that reaches the pending line while the request is still waiting for the grant is serviced first. The request then goes on from the line's new state, so a victim that the snoop has already cleaned is not written back a second time.

Bus command encoding: 1 = read-miss, 2 = write-miss, 3 = write-back, 0 = no command. Address bits [1:0] select the line and the upper bits form the tag.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. bus_req, bus_out_valid, cpu_ready and snp_abort are all low.
- R2: A read that finds its tag in a Shared or Exclusive line raises cpu_ready in the same cycle, returns the line word on cpu_rdata and requests no bus.
- R3: A write that finds its tag in an Exclusive line raises cpu_ready in the same cycle, stores cpu_wdata into the line and requests no bus.
- R4: A read miss places command 1 with the request address on the bus. After the fill the line is Shared and holds the filled word.
- R5: A write to an Invalid line, or to a line whose tag matches but whose state is Shared, places command 2. After the fill the line is Exclusive.
- R6: A miss that displaces an Exclusive line of another tag first places command 3, carrying the victim address and its dirty word. The miss command follows in the next cycle.
- R7: A foreign write-miss (command 2) that matches a Shared line makes it Invalid without raising snp_abort.
- R8: A foreign read-miss (command 1) that matches an Exclusive line raises snp_abort in the same cycle with the dirty word on snp_data, and leaves the line Shared.
- R9: A foreign write-miss that matches an Exclusive line raises snp_abort with the dirty word, and leaves the line Invalid.
- R10: bus_req rises the cycle after a miss is presented. No transaction is placed and the pending line's state does not change, except through snooping, until bus_gnt has been seen.
- R11: A snoop to the pending line's current contents during arbitration is serviced at once. The request then restarts from the new state: no write-back is issued if the snoop already cleaned the victim.
- R12: Snoops that carry this cache's own requester ID, and snooped write-back commands (command 3), change no line and raise no abort.
- R13: cpu_ready stays low from the cycle a miss is presented until the fill has completed.
- R14: With cpu_valid held, cpu_ready rises exactly one cycle after the cycle in which mem_rvalid completes the fill, and bus_req drops at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request completes on this edge |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| bus_req | output | 1 | Bus requested or held |
| bus_gnt | input | 1 | Bus granted |
| bus_out_valid | output | 1 | Own transaction on the bus this cycle |
| bus_out_cmd | output | 2 | Own command (1 read-miss, 2 write-miss, 3 write-back) |
| bus_out_addr | output | ADDR_W | Own transaction address |
| bus_out_data | output | DATA_W | Write-back word |
| bus_out_id | output | ID_W | Own requester ID |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_cmd | input | 2 | Observed command |
| snp_addr | input | ADDR_W | Observed address |
| snp_id | input | ID_W | Observed requester ID |
| snp_abort | output | 1 | Dirty hit: memory must suppress its reply |
| snp_data | output | DATA_W | Dirty word supplied on abort |
| mem_rvalid | input | 1 | Fill word present |
| mem_rdata | input | DATA_W | Fill word |

## Verification
Hits and snoop responses are combinational on registered line state. The bench therefore samples cpu_ready, cpu_rdata, snp_abort and snp_data shortly after driving the inputs at the falling edge, within that same cycle. A miss shows bus_req one cycle after it is presented. The write-back or miss command appears in the cycle after the first sampled grant. cpu_ready appears exactly one cycle after the fill cycle. The bench counts cycles inside each request and checks each of these events at the cycle where it is due. A reference model of line states, tags, words and memory is updated at the same points the design commits its state, so each check compares against a value the model computed independently.

// File: rtl/msi_pkg.sv
// Shared types of the snooping coherence controller.
// Assumes nothing beyond the two-bit encodings fixed here.
package msi_pkg;

    // Coherence state of one cache line
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } line_st_e;

    // Bus command encoding, visible at the ports
    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RD_MISS = 2'd1,
        CMD_WR_MISS = 2'd2,
        CMD_WB      = 2'd3
    } bus_cmd_e;

    // Request sequencer phases
    typedef enum logic [2:0] {
        FS_IDLE = 3'd0,
        FS_ARB  = 3'd1,
        FS_WB   = 3'd2,
        FS_MISS = 3'd3,
        FS_FILL = 3'd4
    } fsm_e;

endpackage

// File: rtl/msi_line_store.sv
// Tag, data and state registers of the direct-mapped cache, with two
// combinational read ports and two write ports. The snoop port writes
// state only and wins over the sequencer port on the state field.
// Assumes the two write ports never target one line with conflicting
// intent; the top guarantees this by gating CPU hits on snoop clashes.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_we,
    input  logic [IDX_W-1:0]  upd_idx,
    input  line_st_e          upd_state,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  line_st_e          snp_state,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Line registers: reset to Invalid, then apply snoop and sequencer writes
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]   <= ST_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else begin
                if (snp_we && (snp_idx == IDX_W'(i))) begin
                    st_q[i] <= snp_state;
                end else if (upd_we && (upd_idx == IDX_W'(i))) begin
                    st_q[i] <= upd_state;
                end
                if (upd_we && (upd_idx == IDX_W'(i))) begin
                    tag_q[i]  <= upd_tag;
                    data_q[i] <= upd_data;
                end
            end
        end
    end

    // Read port A: CPU side and pending request
    always_comb begin
        ra_state = st_q[ra_idx];
        ra_tag   = tag_q[ra_idx];
        ra_data  = data_q[ra_idx];
    end

    // Read port B: snoop side
    always_comb begin
        rb_state = st_q[rb_idx];
        rb_tag   = tag_q[rb_idx];
        rb_data  = data_q[rb_idx];
    end

endmodule

// File: rtl/msi_snoop_unit.sv
// Decodes one observed bus transaction against the addressed line and
// produces the state downgrade, the abort toward memory and the dirty
// word. Assumes the bus shows at most one transaction per cycle and that
// no foreign transaction is shown while this cache owns the bus.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input  logic              snp_valid,
    input  bus_cmd_e          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic [IDX_W-1:0]  rb_idx,
    input  line_st_e          rb_state,
    input  logic [ADDR_W-IDX_W-1:0] rb_tag,
    input  logic [DATA_W-1:0] rb_data,
    output logic              st_we,
    output line_st_e          st_new,
    output logic              abort,
    output logic [DATA_W-1:0] wb_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic foreign;
    logic match;

    // Snoop decision: foreign misses that match a valid line downgrade it
    always_comb begin
        rb_idx  = snp_addr[IDX_W-1:0];
        foreign = snp_valid && (snp_id != ID_W'(MY_ID));
        match   = (rb_state != ST_INV) && (rb_tag == snp_addr[ADDR_W-1:IDX_W]);
        st_we   = 1'b0;
        st_new  = rb_state;
        abort   = 1'b0;
        wb_data = rb_data;
        if (foreign && match) begin
            unique case (snp_cmd)
                CMD_RD_MISS: begin
                    if (rb_state == ST_EXC) begin
                        st_we  = 1'b1;
                        st_new = ST_SHR;
                        abort  = 1'b1;
                    end
                end
                CMD_WR_MISS: begin
                    st_we  = 1'b1;
                    st_new = ST_INV;
                    abort  = (rb_state == ST_EXC);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msi_req_fsm.sv
// CPU-side hit logic and the bus sequencer for misses: request the bus,
// after the grant write back a dirty victim if one is still present,
// place the miss, wait for the fill, then return to idle where the held
// request completes as a hit. The victim check happens at the grant, so
// a snoop serviced during arbitration restarts the request from the new
// state. Assumes the CPU holds its request stable until cpu_ready.
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              bus_out_valid,
    output bus_cmd_e          bus_out_cmd,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snoop_clash,
    output logic [IDX_W-1:0]  ra_idx,
    input  line_st_e          line_state,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_we,
    output line_st_e          upd_state,
    output logic [ADDR_W-IDX_W-1:0] upd_tag,
    output logic [DATA_W-1:0] upd_data,
    output logic              in_arb,
    output logic              in_fill
);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_e              st_q, st_d;
    logic              req_wr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  cpu_tag;
    logic              hit;
    logic              victim_dirty;

    // Index selection and hit detection on the CPU read port
    always_comb begin
        req_idx      = req_addr_q[IDX_W-1:0];
        req_tag      = req_addr_q[ADDR_W-1:IDX_W];
        cpu_tag      = cpu_addr[ADDR_W-1:IDX_W];
        ra_idx       = (st_q == FS_IDLE) ? cpu_addr[IDX_W-1:0] : req_idx;
        hit          = (line_state != ST_INV) && (line_tag == cpu_tag) &&
                       (!cpu_write || (line_state == ST_EXC));
        cpu_ready    = (st_q == FS_IDLE) && cpu_valid && hit && !snoop_clash;
        cpu_rdata    = line_data;
        victim_dirty = (line_state == ST_EXC) && (line_tag != req_tag);
        in_arb       = (st_q == FS_ARB);
        in_fill      = (st_q == FS_FILL);
    end

    // Bus drive and line update for the current phase
    always_comb begin
        bus_req       = 1'b0;
        bus_out_valid = 1'b0;
        bus_out_cmd   = CMD_NONE;
        bus_out_addr  = '0;
        bus_out_data  = '0;
        upd_we        = 1'b0;
        upd_state     = line_state;
        upd_tag       = line_tag;
        upd_data      = line_data;
        unique case (st_q)
            FS_IDLE: begin
                if (cpu_ready && cpu_write) begin
                    upd_we   = 1'b1;
                    upd_data = cpu_wdata;
                end
            end
            FS_ARB: begin
                bus_req = 1'b1;
            end
            FS_WB: begin
                bus_req       = 1'b1;
                bus_out_valid = 1'b1;
                bus_out_cmd   = CMD_WB;
                bus_out_addr  = {line_tag, req_idx};
                bus_out_data  = line_data;
                upd_we        = 1'b1;
                upd_state     = ST_INV;
            end
            FS_MISS: begin
                bus_req       = 1'b1;
                bus_out_valid = 1'b1;
                bus_out_cmd   = req_wr_q ? CMD_WR_MISS : CMD_RD_MISS;
                bus_out_addr  = req_addr_q;
            end
            FS_FILL: begin
                bus_req = 1'b1;
                if (mem_rvalid) begin
                    upd_we    = 1'b1;
                    upd_state = req_wr_q ? ST_EXC : ST_SHR;
                    upd_tag   = req_tag;
                    upd_data  = mem_rdata;
                end
            end
            default: ;
        endcase
    end

    // Next phase: the victim is judged at the grant, not at the miss
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE: if (cpu_valid && !hit && !snoop_clash) st_d = FS_ARB;
            FS_ARB:  if (bus_gnt) st_d = victim_dirty ? FS_WB : FS_MISS;
            FS_WB:   st_d = FS_MISS;
            FS_MISS: st_d = FS_FILL;
            FS_FILL: if (mem_rvalid) st_d = FS_IDLE;
            default: st_d = FS_IDLE;
        endcase
    end

    // Phase and captured request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= FS_IDLE;
            req_wr_q   <= 1'b0;
            req_addr_q <= '0;
        end else begin
            st_q <= st_d;
            if ((st_q == FS_IDLE) && (st_d == FS_ARB)) begin
                req_wr_q   <= cpu_write;
                req_addr_q <= cpu_addr;
            end
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
// Top of the per-cache coherence controller: line registers, snoop
// decoder and request sequencer. Snoop responses are combinational on
// the observed transaction. A CPU access to a line that a snoop updates
// in the same cycle is held off for that cycle. Assumes bus_gnt is never
// given in a cycle that also shows a foreign transaction, and that no
// foreign transaction appears while this cache holds the bus.
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_out_valid,
    output logic [1:0]        bus_out_cmd,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data,
    output logic [ID_W-1:0]   bus_out_id,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ra_idx, rb_idx;
    line_st_e          ra_state, rb_state;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic              upd_we;
    line_st_e          upd_state;
    logic [TAG_W-1:0]  upd_tag;
    logic [DATA_W-1:0] upd_data;
    logic              snp_st_we;
    line_st_e          snp_st_new;
    bus_cmd_e          out_cmd;
    logic              in_arb, in_fill;
    logic              snoop_upd;
    logic [1:0]        line_st;

    // Snoop touches the line the CPU side is looking at this cycle
    always_comb begin
        snoop_upd  = snp_st_we && (rb_idx == ra_idx);
        line_st    = ra_state;
        bus_out_cmd = out_cmd;
        bus_out_id = ID_W'(MY_ID);
    end

    msi_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_we   (upd_we),
        .upd_idx  (ra_idx),
        .upd_state(upd_state),
        .upd_tag  (upd_tag),
        .upd_data (upd_data),
        .snp_we   (snp_st_we),
        .snp_idx  (rb_idx),
        .snp_state(snp_st_new),
        .ra_idx   (ra_idx),
        .ra_state (ra_state),
        .ra_tag   (ra_tag),
        .ra_data  (ra_data),
        .rb_idx   (rb_idx),
        .rb_state (rb_state),
        .rb_tag   (rb_tag),
        .rb_data  (rb_data)
    );

    msi_snoop_unit #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W),
        .ID_W  (ID_W),
        .MY_ID (MY_ID)
    ) snoop_i (
        .snp_valid(snp_valid),
        .snp_cmd  (bus_cmd_e'(snp_cmd)),
        .snp_addr (snp_addr),
        .snp_id   (snp_id),
        .rb_idx   (rb_idx),
        .rb_state (rb_state),
        .rb_tag   (rb_tag),
        .rb_data  (rb_data),
        .st_we    (snp_st_we),
        .st_new   (snp_st_new),
        .abort    (snp_abort),
        .wb_data  (snp_data)
    );

    msi_req_fsm #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_valid    (cpu_valid),
        .cpu_write    (cpu_write),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_ready    (cpu_ready),
        .cpu_rdata    (cpu_rdata),
        .bus_gnt      (bus_gnt),
        .bus_req      (bus_req),
        .bus_out_valid(bus_out_valid),
        .bus_out_cmd  (out_cmd),
        .bus_out_addr (bus_out_addr),
        .bus_out_data (bus_out_data),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .snoop_clash  (snoop_upd),
        .ra_idx       (ra_idx),
        .line_state   (ra_state),
        .line_tag     (ra_tag),
        .line_data    (ra_data),
        .upd_we       (upd_we),
        .upd_state    (upd_state),
        .upd_tag      (upd_tag),
        .upd_data     (upd_data),
        .in_arb       (in_arb),
        .in_fill      (in_fill)
    );

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
// Temporal checks on the coherence controller, attached by bind.
// Assumes the same bus rules as the top module.
module msi_snoop_ctrl_chk #(
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_ready,
    input logic            bus_req,
    input logic            bus_gnt,
    input logic            bus_out_valid,
    input logic [1:0]      bus_out_cmd,
    input logic            snp_valid,
    input logic [1:0]      snp_cmd,
    input logic [ID_W-1:0] snp_id,
    input logic            snp_abort,
    input logic            mem_rvalid,
    input logic            in_arb,
    input logic            in_fill,
    input logic            snoop_upd,
    input logic [1:0]      line_st
);

    // R10: a transaction follows a seen grant or another own transaction
    p_txn_after_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |-> ($past(bus_gnt) || $past(bus_out_valid)));

    // R10: while arbitrating, only a snoop may change the pending line
    p_hold_in_arb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arb && !snoop_upd) |=> (line_st == $past(line_st)));

    // R6: a write-back is followed at once by the miss command
    p_wb_then_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out_valid && (bus_out_cmd == 2'd3)) |=>
        (bus_out_valid && ((bus_out_cmd == 2'd1) || (bus_out_cmd == 2'd2))));

    // R12: abort only for foreign miss commands
    p_abort_foreign_r12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snp_valid && (snp_id != ID_W'(MY_ID)) &&
                       ((snp_cmd == 2'd1) || (snp_cmd == 2'd2))));

    // R13: the CPU is never answered while the bus is held
    p_ready_low_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    // R14: a completed fill releases the bus
    p_fill_release_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && mem_rvalid) |=> !bus_req);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
    .ID_W (ID_W),
    .MY_ID(MY_ID)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_ready    (cpu_ready),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_out_valid(bus_out_valid),
    .bus_out_cmd  (bus_out_cmd),
    .snp_valid    (snp_valid),
    .snp_cmd      (snp_cmd),
    .snp_id       (snp_id),
    .snp_abort    (snp_abort),
    .mem_rvalid   (mem_rvalid),
    .in_arb       (in_arb),
    .in_fill      (in_fill),
    .snoop_upd    (snoop_upd),
    .line_st      (line_st)
);

// File: tb/msi_snoop_ctrl_tb.sv
// Self-checking bench: plays the bus arbiter, memory and peer caches,
// keeps a reference model of lines and memory, and compares every
// CPU answer, bus command and snoop response at its due cycle.
module msi_snoop_ctrl_tb_top;

    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;
    localparam int DATA_W = 8;
    localparam int ID_W   = 2;
    localparam int MY_ID  = 0;
    localparam int INV = 0, SHR = 1, EXC = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_valid, cpu_write;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    logic              cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req, bus_gnt, bus_out_valid;
    logic [1:0]        bus_out_cmd;
    logic [ADDR_W-1:0] bus_out_addr;
    logic [DATA_W-1:0] bus_out_data;
    logic [ID_W-1:0]   bus_out_id;
    logic              snp_valid;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic [ID_W-1:0]   snp_id;
    logic              snp_abort;
    logic [DATA_W-1:0] snp_data;
    logic              mem_rvalid;
    logic [DATA_W-1:0] mem_rdata;

    int nchk  = 0;
    int nfail = 0;

    int              m_st  [4];
    logic [5:0]      m_tag [4];
    logic [7:0]      m_dat [4];
    logic [7:0]      mem   [256];

    always #10 clk = ~clk;

    msi_snoop_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_out_valid(bus_out_valid),
        .bus_out_cmd(bus_out_cmd), .bus_out_addr(bus_out_addr),
        .bus_out_data(bus_out_data), .bus_out_id(bus_out_id),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_id(snp_id), .snp_abort(snp_abort), .snp_data(snp_data),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [7:0] a, input bit wr);
        int i = int'(a[1:0]);
        return (m_st[i] != INV) && (m_tag[i] == a[7:2]) && (!wr || m_st[i] == EXC);
    endfunction

    // Compare a snoop response already on the ports, then update the model
    task automatic snoop_check(input logic [1:0] cmd, input logic [7:0] a, input logic [1:0] id);
        int    i     = int'(a[1:0]);
        bit    match = (m_st[i] != INV) && (m_tag[i] == a[7:2]);
        bit    frn   = (id != 2'(MY_ID));
        bit    ab    = frn && match && (m_st[i] == EXC) && (cmd == 2'd1 || cmd == 2'd2);
        string lbl;
        if (!frn || cmd == 2'd3 || cmd == 2'd0) lbl = "R12";
        else if (cmd == 2'd1) lbl = "R8";
        else if (m_st[i] == EXC) lbl = "R9";
        else lbl = "R7";
        chk(lbl, "snp_abort", int'(snp_abort), int'(ab));
        if (ab) begin
            chk(lbl, "snp_data", int'(snp_data), int'(m_dat[i]));
            mem[a] = m_dat[i];
        end
        if (frn && match) begin
            if (cmd == 2'd1 && m_st[i] == EXC) m_st[i] = SHR;
            else if (cmd == 2'd2) m_st[i] = INV;
        end
    endtask

    task automatic snoop_op(input logic [1:0] cmd, input logic [7:0] a, input logic [1:0] id);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_id = id;
        #1;
        snoop_check(cmd, a, id);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // One CPU request, optionally with a snoop to the victim during arbitration
    task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                          input bit race, input logic [1:0] rcmd);
        int         i        = int'(a[1:0]);
        bit         exp_hit  = m_hit(a, wr);
        bit         wb_exp   = !exp_hit && (m_st[i] == EXC) && (m_tag[i] != a[7:2]);
        logic [7:0] victim_a = {m_tag[i], a[1:0]};
        bit         done = 0, wb_seen = 0, miss_seen = 0, race_done = 0, race_now;
        int         arb_cnt = 0, fill_due = -1, ready_due = -1, cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
            snp_valid = 1'b0; mem_rvalid = 1'b0;
            if (bus_req) arb_cnt++; else arb_cnt = 0;
            bus_gnt = (arb_cnt >= 3);
            if (fill_due == cyc) begin mem_rvalid = 1'b1; mem_rdata = mem[a]; end
            race_now = race && !race_done && bus_req && (arb_cnt == 1);
            if (race_now) begin
                snp_valid = 1'b1; snp_cmd = rcmd; snp_addr = victim_a; snp_id = 2'd1;
            end
            #1;
            if (race_now) begin
                snoop_check(rcmd, victim_a, 2'd1);
                wb_exp = (m_st[i] == EXC) && (m_tag[i] != a[7:2]);
                race_done = 1;
            end
            if (cyc == 0) chk(exp_hit ? (wr ? "R3" : "R2") : "R13", "ready on first cycle",
                              int'(cpu_ready), int'(exp_hit));
            if (cyc == 1 && !exp_hit) chk("R10", "bus_req after miss", int'(bus_req), 1);
            if (bus_req && cpu_ready) chk("R13", "ready while bus held", 1, 0);
            if (bus_out_valid) begin
                if (bus_out_cmd == 2'd3) begin
                    wb_seen = 1;
                    chk("R6", "wb addr", int'(bus_out_addr), int'(victim_a));
                    chk("R6", "wb data", int'(bus_out_data), int'(m_dat[i]));
                    mem[bus_out_addr] = bus_out_data;
                    m_st[i] = INV;
                end else begin
                    miss_seen = 1;
                    chk(wr ? "R5" : "R4", "miss cmd", int'(bus_out_cmd), wr ? 2 : 1);
                    chk(wr ? "R5" : "R4", "miss addr", int'(bus_out_addr), int'(a));
                    chk("R6", "wb before miss", int'(wb_seen), int'(wb_exp));
                    fill_due = cyc + 1;
                end
            end
            if (mem_rvalid) begin
                m_st[i] = wr ? EXC : SHR; m_tag[i] = a[7:2]; m_dat[i] = mem[a];
                ready_due = cyc + 1;
            end
            if (cpu_ready) begin
                if (miss_seen) chk("R14", "ready cycle after fill", cyc, ready_due);
                if (!wr) chk(miss_seen ? "R4" : "R2", "read data", int'(cpu_rdata), int'(m_dat[i]));
                else m_dat[i] = wd;
                done = 1;
            end
            cyc++;
        end
        if (!done) chk("R13", "request never completed", 0, 1);
        if (race) chk("R11", "write-back after race", int'(wb_seen), int'(wb_exp));
        @(negedge clk);
        cpu_valid = 1'b0; bus_gnt = 1'b0; mem_rvalid = 1'b0; snp_valid = 1'b0;
        if (bus_req) chk("R14", "bus released after op", 1, 0);
    endtask

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'hA5;
        for (int k = 0; k < 4; k++) begin m_st[k] = INV; m_tag[k] = '0; m_dat[k] = '0; end
        rst_n = 1'b0; cpu_valid = 0; cpu_write = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 0; snp_valid = 0; snp_cmd = '0; snp_addr = '0; snp_id = '0;
        mem_rvalid = 0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "bus_req after reset", int'(bus_req), 0);
        chk("R1", "bus_out_valid after reset", int'(bus_out_valid), 0);
        chk("R1", "cpu_ready after reset", int'(cpu_ready), 0);
        chk("R1", "snp_abort after reset", int'(snp_abort), 0);
        chk("R1", "own id", int'(bus_out_id), MY_ID);

        // Directed corners
        cpu_op(0, 8'h10, 8'h00, 0, 2'd0);     // R1/R4 cold read miss
        cpu_op(0, 8'h10, 8'h00, 0, 2'd0);     // R2 read hit in Shared
        cpu_op(1, 8'h10, 8'h3C, 0, 2'd0);     // R5 upgrade from Shared
        cpu_op(1, 8'h10, 8'h4D, 0, 2'd0);     // R3 write hit
        cpu_op(0, 8'h20, 8'h00, 0, 2'd0);     // R6 dirty victim written back
        snoop_op(2'd2, 8'h20, 2'd2);          // R7 invalidate Shared
        cpu_op(0, 8'h20, 8'h00, 0, 2'd0);     // miss again after R7
        cpu_op(1, 8'h31, 8'h77, 0, 2'd0);     // R5 write to Invalid
        snoop_op(2'd1, 8'h31, 2'd0);          // R12 own id ignored
        snoop_op(2'd3, 8'h31, 2'd3);          // R12 write-back cmd ignored
        cpu_op(1, 8'h31, 8'h78, 0, 2'd0);     // still Exclusive after R12
        snoop_op(2'd1, 8'h31, 2'd1);          // R8 dirty read-miss snoop
        cpu_op(0, 8'h31, 8'h00, 0, 2'd0);     // R8 line now Shared, hit
        cpu_op(1, 8'h31, 8'h99, 0, 2'd0);     // back to Exclusive
        snoop_op(2'd2, 8'h31, 2'd3);          // R9 dirty write-miss snoop
        cpu_op(1, 8'h42, 8'h11, 0, 2'd0);
        cpu_op(0, 8'h82, 8'h00, 1, 2'd1);     // R11 race cleans victim, no write-back
        cpu_op(1, 8'h43, 8'h22, 0, 2'd0);
        cpu_op(1, 8'h83, 8'h33, 1, 2'd2);     // R11 race invalidates victim

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a  = 8'((($urandom % 4) << 2) | ($urandom % 4));
            logic [1:0] id = 2'($urandom % 4);
            if (($urandom % 10) < 6) begin
                cpu_op(1'($urandom % 2), a, 8'($urandom), (($urandom % 4) == 0),
                       2'(1 + ($urandom % 2)));
            end else begin
                snoop_op(2'(1 + ($urandom % 3)), a, id);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule